// File: doc/BRIEF.md
# Fault-Latching Status Register with Interrupt

This block is a small two-wire bus slave that holds one status register for a power-stage controller. It has three fault inputs: undervoltage, overcurrent and overtemperature. Each one sets a sticky bit in the status register and pulls an active-low, open-drain interrupt line. Two more conditions, output-disabled and power-bad, are reported as live values only. They are never stored and never raise the interrupt.

Several devices can share the interrupt line. After an interrupt, the host polls each device in turn. To read one device, it writes the device's status register address and then, after a repeated start, reads one byte. The stored fault bits and the interrupt are released only when the host acknowledges that byte. A not-acknowledge, or an aborted transfer, leaves them set. A fault that arrives while the byte is already on its way stays latched after the release.

Both bus pins are modelled as open-drain enables: a 1 pulls the line low. Bus inputs pass through a synchroniser into the system clock. Fault and live inputs are taken to be synchronous to that clock.

Top module: `fault_status_irq`

## Requirements
- R1: Any cycle with a fault input high sets the matching status bit, and `irq_oe` is 1 from the next clock edge. Bit 0 is undervoltage, bit 1 is overcurrent and bit 2 is overtemperature.
- R2: Stored fault bits and `irq_oe` stay set after the fault inputs return low, until a clear by R6.
- R3: Status bit 3 shows `out_disabled` and bit 4 shows `power_bad` as live values; bits 7..5 read 0. Bits 3 and 4 are never stored and never set `irq_oe`.
- R4: The slave pulls SDA low in the acknowledge slot after its own 7-bit address (sent MSB first, followed by the R/W bit) and after the register address byte. For any other address it never drives SDA.
- R5: A read of the status register address returns the 8-bit status byte MSB first, sampled at the end of the address acknowledge of the read.
- R6: When the host acknowledges the status byte (SDA low on the ninth clock), every fault bit that was sent as 1 is cleared. `irq_oe` drops to 0 if no fault bit remains.
- R7: A not-acknowledge of the status byte leaves the stored bits and `irq_oe` unchanged.
- R8: A start or stop condition before the acknowledge clock of the status byte leaves the stored bits and `irq_oe` unchanged.
- R9: A fault that arrives after the status byte has been sampled remains stored, with `irq_oe` still 1, after the host acknowledges that byte.
- R10: A read of any register address other than the status address returns 0x00 and does not clear stored faults.
- R11: `sda_oe` changes only while the synchronised SCL is low.
- R12: Out of reset, `sda_oe` and `irq_oe` are 0 and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| uv_fault | input | 1 | Undervoltage event |
| oc_fault | input | 1 | Overcurrent event |
| ot_fault | input | 1 | Overtemperature event |
| out_disabled | input | 1 | Live output-disabled condition |
| power_bad | input | 1 | Live power-not-good condition |
| irq_oe | output | 1 | 1 pulls the shared interrupt line low |

## Verification
The assertions assume a well-behaved bus master. SDA changes only while SCL is low, except when the master deliberately forms a start or stop. The master never forms a start or stop while the slave is pulling SDA low. Each SCL level also lasts longer than the synchroniser delay. The bench drives SCL with ten-cycle half periods, changes its own data only in the low phase, and places its one aborted transfer on a bit where the slave has released the line. Fault pulses and live levels are applied at falling clock edges, so they are synchronous to the clock.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int NUM_FAULTS = 3;
  localparam int BYTE_W     = 8;
  localparam int POS_UV     = 0;
  localparam int POS_OC     = 1;
  localparam int POS_OT     = 2;
  localparam int POS_DIS    = 3;
  localparam int POS_PBAD   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_TX,
    ST_HOST_ACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/fsr_line_sync.sv
module fsr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/fsr_bus_engine.sv
module fsr_bus_engine
  import fsr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter logic [7:0] STATUS_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              clr_p,
  output logic [BYTE_W-1:0] clr_mask
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, ptr, txsh, tx_load;
  logic              rw, is_status;

  assign tx_load = (ptr == STATUS_ADDR) ? status_byte : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      ptr       <= '0;
      txsh      <= '0;
      rw        <= 1'b0;
      is_status <= 1'b0;
      sda_oe    <= 1'b0;
      clr_p     <= 1'b0;
      clr_mask  <= '0;
    end else begin
      clr_p <= 1'b0;
      if (start_p) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_p) begin
        state <= ST_IDLE;
      end else if (scl_rise) begin
        case (state)
          ST_ADDR, ST_REG: begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          ST_TX: cnt <= cnt + 1'b1;
          ST_HOST_ACK: begin
            if (!sda_s && is_status) begin
              clr_p <= 1'b1;
            end
            state <= ST_SKIP;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        sda_oe <= 1'b0;
        case (state)
          ST_ADDR: begin
            if (cnt == CNT_W'(BYTE_W)) begin
              if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                state  <= ST_ADDR_ACK;
                rw     <= sh[0];
                sda_oe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            cnt <= '0;
            if (rw) begin
              state     <= ST_TX;
              txsh      <= tx_load;
              clr_mask  <= tx_load;
              is_status <= (ptr == STATUS_ADDR);
              sda_oe    <= ~tx_load[BYTE_W-1];
            end else begin
              state <= ST_REG;
            end
          end
          ST_REG: begin
            if (cnt == CNT_W'(BYTE_W)) begin
              ptr    <= sh;
              state  <= ST_REG_ACK;
              sda_oe <= 1'b1;
            end
          end
          ST_REG_ACK: state <= ST_SKIP;
          ST_TX: begin
            if (cnt == CNT_W'(BYTE_W)) begin
              state <= ST_HOST_ACK;
            end else begin
              txsh   <= txsh << 1;
              sda_oe <= ~txsh[BYTE_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: data line enable moves only while the clock line is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R4: the line is pulled only in acknowledge slots or while sending data
  a_r4_oe_states: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ADDR_ACK || state == ST_REG_ACK || state == ST_TX));

  // R6: a clear pulse only follows the host acknowledge slot
  a_r6_clr_after_ack: assert property (@(posedge clk) disable iff (rst)
    clr_p |-> ($past(state) == ST_HOST_ACK && $past(scl_rise)));
endmodule

// File: rtl/fsr_fault_latch.sv
module fsr_fault_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fault_i,
  input  logic         clr_p,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] latched,
  output logic         irq_oe
);
  logic [N-1:0] keep, nxt;

  assign keep = clr_p ? ~clr_mask : '1;
  assign nxt  = (latched & keep) | fault_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= '0;
      irq_oe  <= 1'b0;
    end else begin
      latched <= nxt;
      irq_oe  <= |nxt;
    end
  end

  // R1: a fault raises the interrupt on the next edge
  a_r1_fault_raises: assert property (@(posedge clk) disable iff (rst)
    (|fault_i) |=> irq_oe);

  // R2: without a clear the interrupt holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_oe && !clr_p) |=> irq_oe);

  // R6: a clear covering all stored bits with no new fault releases the line
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (clr_p && !(|fault_i) && ((latched & ~clr_mask) == '0)) |=> !irq_oe);

  // R9: bits that were not sent survive a clear
  a_r9_keep_unsent: assert property (@(posedge clk) disable iff (rst)
    clr_p |=> (($past(latched) & ~$past(clr_mask) & ~latched) == '0));
endmodule

// File: rtl/fault_status_irq.sv
module fault_status_irq
  import fsr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter logic [7:0] STATUS_ADDR = 8'h02,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic uv_fault,
  input  logic oc_fault,
  input  logic ot_fault,
  input  logic out_disabled,
  input  logic power_bad,
  output logic irq_oe
);
  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic clr_p;
  logic [BYTE_W-1:0] clr_mask, status_byte;
  logic [NUM_FAULTS-1:0] faults, latched;

  always_comb begin
    faults         = '0;
    faults[POS_UV] = uv_fault;
    faults[POS_OC] = oc_fault;
    faults[POS_OT] = ot_fault;
    status_byte    = '0;
    status_byte[NUM_FAULTS-1:0] = latched;
    status_byte[POS_DIS]        = out_disabled;
    status_byte[POS_PBAD]       = power_bad;
  end

  fsr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  fsr_bus_engine #(.DEV_ADDR(DEV_ADDR), .STATUS_ADDR(STATUS_ADDR)) u_bus (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .status_byte(status_byte), .sda_oe(sda_oe), .clr_p(clr_p), .clr_mask(clr_mask)
  );

  fsr_fault_latch #(.N(NUM_FAULTS)) u_latch (
    .clk(clk), .rst(rst), .fault_i(faults), .clr_p(clr_p),
    .clr_mask(clr_mask[NUM_FAULTS-1:0]), .latched(latched), .irq_oe(irq_oe)
  );
endmodule

// File: tb/sim_fault_status_irq.sv
module sim_fault_status_irq;
  localparam logic [6:0] DEV  = 7'h08;
  localparam logic [7:0] STAT = 8'h02;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic uv = 1'b0, oc = 1'b0, ot = 1'b0, dis = 1'b0, pbad = 1'b0;
  wire  sda_oe, irq_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0, viol = 0;
  logic oe_prev = 1'b0, oe_seen = 1'b0;

  fault_status_irq #(.DEV_ADDR(DEV), .STATUS_ADDR(STAT)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .uv_fault(uv), .oc_fault(oc), .ot_fault(ot),
    .out_disabled(dis), .power_bad(pbad), .irq_oe(irq_oe)
  );

  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl_m) viol++;
    if (sda_oe) oe_seen = 1'b1;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF); sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF / 2);
    b = sda_line; tick(HALF / 2); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack_n);
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic host_ack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~host_ack);
  endtask

  task automatic read_reg(input logic [6:0] dev, input logic [7:0] ra, input logic host_ack,
                          output logic [7:0] val, output logic acks_ok);
    logic a1, a2, a3;
    bus_start;
    wr_byte({dev, 1'b0}, a1);
    wr_byte(ra, a2);
    bus_start;
    wr_byte({dev, 1'b1}, a3);
    rd_byte(val, host_ack);
    bus_stop;
    acks_ok = ~a1 & ~a2 & ~a3;
  endtask

  task automatic pulse(input logic [2:0] p);
    {ot, oc, uv} = p; tick(1); {ot, oc, uv} = 3'b000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ok, a, b;
    logic [2:0] model;
    logic [1:0] live;
    logic [2:0] pat;
    logic hack;
    void'($urandom(32'd20240611));

    tick(5);
    chk("R12 sda_oe in reset", sda_oe, 0);
    chk("R12 irq_oe in reset", irq_oe, 0);
    rst = 1'b0; tick(5);
    chk("R12 irq_oe after reset", irq_oe, 0);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R12 status after reset", v, 8'h00);
    chk("R4 acks own address", ok, 1);

    // R1 / R2: pulse overcurrent, check latch and hold
    pulse(3'b010);
    chk("R1 irq after fault", irq_oe, 1);
    tick(40);
    chk("R2 irq holds", irq_oe, 1);
    // R10: other register reads zero and does not clear
    read_reg(DEV, 8'h03, 1'b1, v, ok);
    chk("R10 other reg zero", v, 8'h00);
    chk("R10 no clear", irq_oe, 1);
    // R7: NACK keeps
    read_reg(DEV, STAT, 1'b0, v, ok);
    chk("R5 status value", v, 8'h02);
    chk("R7 nack keeps irq", irq_oe, 1);
    // R6: ACK clears
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R5 status value again", v, 8'h02);
    chk("R6 ack clears irq", irq_oe, 0);

    // R3: live bits visible, never latched
    dis = 1'b1; tick(20);
    chk("R3 dis no irq", irq_oe, 0);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R3 dis live bit3", v, 8'h08);
    dis = 1'b0; pbad = 1'b1; tick(20);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R3 pbad live bit4", v, 8'h10);
    pbad = 1'b0; tick(5);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R3 live not stored", v, 8'h00);
    chk("R3 live no irq", irq_oe, 0);

    // R4: foreign address, slave silent
    pulse(3'b100);
    oe_seen = 1'b0;
    read_reg(7'h09, STAT, 1'b1, v, ok);
    chk("R4 foreign never driven", oe_seen, 0);
    chk("R4 foreign reads idle", v, 8'hFF);
    chk("R4 foreign keeps irq", irq_oe, 1);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R5 overtemp bit2", v, 8'h04);
    chk("R6 cleared", irq_oe, 0);

    // R8: restart before the acknowledge clock (byte 0x19, abort on bit4)
    pulse(3'b001); dis = 1'b1; pbad = 1'b1;
    bus_start;
    wr_byte({DEV, 1'b0}, a); wr_byte(STAT, a);
    bus_start;
    wr_byte({DEV, 1'b1}, a);
    v = 8'h00;
    for (int i = 7; i >= 5; i--) recv_bit(v[i]);
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(HALF);
    bus_stop;
    chk("R8 partial bits", v, 8'h00);
    chk("R8 abort keeps irq", irq_oe, 1);
    read_reg(DEV, STAT, 1'b0, v, ok);
    chk("R8 status intact", v, 8'h19);
    dis = 1'b0; pbad = 1'b0;

    // R9: fault after sampling survives clear
    bus_start;
    wr_byte({DEV, 1'b0}, a); wr_byte(STAT, a);
    bus_start;
    wr_byte({DEV, 1'b1}, a);
    pulse(3'b010);
    rd_byte(v, 1'b1);
    bus_stop;
    chk("R9 sampled byte", v, 8'h01);
    chk("R9 irq kept", irq_oe, 1);
    read_reg(DEV, STAT, 1'b1, v, ok);
    chk("R9 late fault stored", v, 8'h02);
    chk("R6 final clear", irq_oe, 0);

    // random mix (R1 R3 R5 R6 R7)
    model = 3'b000;
    for (int k = 0; k < 24; k++) begin
      pat  = 3'($urandom % 8);
      live = 2'($urandom % 4);
      hack = 1'($urandom % 2);
      if (pat != 0) pulse(pat);
      {pbad, dis} = live;
      model = model | pat;
      tick(3);
      chk("R1 random irq", irq_oe, |model);
      read_reg(DEV, STAT, hack, v, ok);
      chk("R5 random status", v, {3'b000, live, model});
      if (hack) model = 3'b000;
      chk("R6 R7 random irq after read", irq_oe, |model);
    end

    chk("R11 oe moved with SCL high", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule